// File: doc/BRIEF.md
# Virtual-Channel Input Pipeline Sequencer

This block steers the flits of a single input virtual channel through a four-stage router pipeline. The stages are routing computation (RC), virtual-channel allocation (VA), switch allocation (SA) and switch traversal (ST). It looks at the flit waiting at the front of the channel's FIFO and at the routing result. It tracks the channel's packet state and raises requests to the VC allocator and the switch allocator. When a switch grant is won it fires a dequeue strobe, which moves the flit out of the FIFO into the crossbar. The flit then crosses the crossbar in the following cycle.

A packet's opening flit works through every stage. The flits that follow it reuse the output port and downstream VC recorded for that packet and compete only for the switch. A closing flit releases the channel. A speculative mode can be selected, in which the opening flit asks for a VC and for the switch in the same cycle. The routing function, both allocators, the FIFO and the crossbar sit outside this block.

Top module: `vc_seq`

## Requirements
- R1: While reset is asserted, `busy`, `vc_req`, `sw_req`, `sw_spec` and `deq` are all 0, whatever the inputs are.
- R2: The `front_type` codes are 2'b00 opening flit, 2'b01 middle flit, 2'b10 closing flit and 2'b11 single-flit packet. Let cycle 0 be the first cycle an opening flit sits at the front of an idle channel. With routing ready and every grant given at once, `vc_req` rises in cycle 2 and `deq` fires in cycle 3, so the flit crosses in cycle 4.
- R3: Middle and closing flits skip RC and VA. Each one requests the switch as soon as it reaches the front, provided credit is available. Flits of a packet dequeue in strict order, one per cycle, when nothing blocks them.
- R4: The cycle after a closing or single flit dequeues, `busy` is 0.
- R5: An opening flit cannot begin RC until the previous packet's closing flit has dequeued. After that closing dequeue in cycle t, the next opening flit dequeues no earlier than cycle t+4.
- R6: While `route_valid` is low in RC, the channel stays in RC and raises no request.
- R7: While VA is not granted in normal mode, `vc_req` stays high, `sw_req` stays low and `req_port` holds the routed port.
- R8: A channel holding a VC with `credit_ok` low does not request the switch and does not dequeue.
- R9: `deq` fires only in a cycle where `sw_req` and `sw_gnt` are both high. A request with no grant is held until granted.
- R10: With `spec_en` high, the opening flit raises `vc_req`, `sw_req` and `sw_spec` together in cycle 2. If both grants arrive, it dequeues in cycle 2.
- R11: In speculative mode, a switch grant that arrives without a VC grant is dropped: there is no dequeue and both requests are raised again. A VC grant that arrives without a switch grant moves the channel to normal switch requests from the next cycle.
- R12: `sw_spec` is 1 only on a speculative request, that is, while VA is pending. Every switch request made after a VC is held carries `sw_spec`=0, so the allocator can rank it higher.
- R13: A middle or closing flit at the front of an idle channel is ignored: no request is raised, nothing is dequeued and `busy` stays 0.
- R14: `req_port` holds the routing result captured in RC, and `out_vc` holds the VC id granted in VA. Both are kept unchanged for the rest of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_en | input | 1 | Selects speculative VA/SA overlap |
| front_valid | input | 1 | A flit is waiting at the FIFO front |
| front_type | input | 2 | Kind of the front flit (codes in R2) |
| route_valid | input | 1 | Routing result ready during RC |
| route_port | input | PORT_W | Output port computed for the packet |
| vc_gnt | input | 1 | VC allocator grant |
| vc_gnt_id | input | VC_W | Downstream VC granted |
| sw_gnt | input | 1 | Switch allocator grant |
| credit_ok | input | 1 | Downstream VC has a free buffer |
| vc_req | output | 1 | Request to the VC allocator |
| sw_req | output | 1 | Request to the switch allocator |
| sw_spec | output | 1 | Current switch request is speculative |
| req_port | output | PORT_W | Output port of the current packet |
| out_vc | output | VC_W | Downstream VC of the current packet |
| deq | output | 1 | Pop the front flit into the crossbar |
| busy | output | 1 | Channel holds a packet in progress |

## Verification
In speculative mode, VC allocation and switch allocation happen in the same cycle. Their outcomes can disagree in two ways. The bench provokes each way by giving only one of the two grants in the speculative cycle. It judges the result by checking that a lone switch grant produces no dequeue and the pair of requests is raised again. It also checks that a lone VC grant produces a normal-priority switch request, and a dequeue, one cycle later. A second overlap occurs when a closing flit dequeues while the next opening flit is waiting behind it. The bench times that opening flit's dequeue against the closing flit's dequeue.

// File: rtl/vc_seq_pkg.sv
package vc_seq_pkg;

  typedef enum logic [1:0] {
    FK_OPEN  = 2'b00,
    FK_MID   = 2'b01,
    FK_CLOSE = 2'b10,
    FK_SOLO  = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROUTE,
    ST_VCWAIT,
    ST_ACTIVE
  } chan_state_e;

  // flit starts a packet: opening or single
  function automatic logic opens_pkt(input logic [1:0] kind);
    return (kind == FK_OPEN) || (kind == FK_SOLO);
  endfunction

  // flit ends a packet: closing or single
  function automatic logic closes_pkt(input logic [1:0] kind);
    return kind[1];
  endfunction

  // cycles from reaching the front until the opening flit dequeues
  function automatic int open_deq_delay(input logic spec);
    return spec ? 2 : 3;
  endfunction

endpackage

// File: rtl/vc_seq_fsm.sv
module vc_seq_fsm
  import vc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        front_valid,
  input  logic [1:0]  front_type,
  input  logic        route_valid,
  input  logic        va_won,
  input  logic        sa_won,
  output chan_state_e state
);

  chan_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (front_valid && opens_pkt(front_type)) state_d = ST_ROUTE;
      ST_ROUTE:  if (route_valid) state_d = ST_VCWAIT;
      ST_VCWAIT: if (va_won) state_d = (sa_won && closes_pkt(front_type)) ? ST_IDLE : ST_ACTIVE;
      ST_ACTIVE: if (sa_won && closes_pkt(front_type)) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/vc_seq_req.sv
module vc_seq_req
  import vc_seq_pkg::*;
(
  input  chan_state_e state,
  input  logic        spec_en,
  input  logic        front_valid,
  input  logic        credit_ok,
  input  logic        vc_gnt,
  input  logic        sw_gnt,
  output logic        vc_req,
  output logic        sw_req,
  output logic        sw_spec,
  output logic        va_won,
  output logic        sa_won,
  output logic        spec_lost
);

  logic in_va, in_act;

  always_comb begin
    in_va     = (state == ST_VCWAIT);
    in_act    = (state == ST_ACTIVE);
    vc_req    = in_va;
    // a fresh downstream VC is empty, so speculation skips the credit test
    sw_spec   = in_va && spec_en && front_valid;
    sw_req    = sw_spec || (in_act && front_valid && credit_ok);
    va_won    = in_va && vc_gnt;
    sa_won    = sw_req && sw_gnt && (!sw_spec || vc_gnt);
    spec_lost = sw_spec && sw_gnt && !vc_gnt;
  end

endmodule

// File: rtl/vc_seq_ctx.sv
module vc_seq_ctx #(
  parameter int PORT_W = 3,
  parameter int VC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              route_take,
  input  logic [PORT_W-1:0] route_port,
  input  logic              va_won,
  input  logic [VC_W-1:0]   vc_gnt_id,
  output logic [PORT_W-1:0] port_q,
  output logic [VC_W-1:0]   vc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= '0;
      vc_q   <= '0;
    end else begin
      if (route_take) port_q <= route_port;
      if (va_won)     vc_q   <= vc_gnt_id;
    end
  end

endmodule

// File: rtl/vc_seq.sv
module vc_seq
  import vc_seq_pkg::*;
#(
  parameter int PORTS = 5,
  parameter int VCS   = 4,
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int VC_W   = (VCS > 1) ? $clog2(VCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_en,
  input  logic              front_valid,
  input  logic [1:0]        front_type,
  input  logic              route_valid,
  input  logic [PORT_W-1:0] route_port,
  input  logic              vc_gnt,
  input  logic [VC_W-1:0]   vc_gnt_id,
  input  logic              sw_gnt,
  input  logic              credit_ok,
  output logic              vc_req,
  output logic              sw_req,
  output logic              sw_spec,
  output logic [PORT_W-1:0] req_port,
  output logic [VC_W-1:0]   out_vc,
  output logic              deq,
  output logic              busy
);

  chan_state_e state;
  logic va_won, sa_won, spec_lost, route_take;

  vc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .front_valid(front_valid), .front_type(front_type),
    .route_valid(route_valid), .va_won(va_won), .sa_won(sa_won), .state(state)
  );

  vc_seq_req u_req (
    .state(state), .spec_en(spec_en), .front_valid(front_valid), .credit_ok(credit_ok),
    .vc_gnt(vc_gnt), .sw_gnt(sw_gnt), .vc_req(vc_req), .sw_req(sw_req),
    .sw_spec(sw_spec), .va_won(va_won), .sa_won(sa_won), .spec_lost(spec_lost)
  );

  assign route_take = (state == ST_ROUTE) && route_valid;

  vc_seq_ctx #(.PORT_W(PORT_W), .VC_W(VC_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .route_take(route_take), .route_port(route_port),
    .va_won(va_won), .vc_gnt_id(vc_gnt_id), .port_q(req_port), .vc_q(out_vc)
  );

  assign deq  = sa_won;
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/vc_seq_chk.sv
module vc_seq_chk #(
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        front_type,
  input logic              vc_req,
  input logic              vc_gnt,
  input logic              sw_req,
  input logic              sw_gnt,
  input logic              sw_spec,
  input logic              credit_ok,
  input logic              deq,
  input logic              busy,
  input logic [PORT_W-1:0] req_port
);

  p_deq_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> (sw_req && sw_gnt));

  p_credit_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !sw_spec) |-> credit_ok);

  p_spec_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_spec |-> vc_req);

  p_spec_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_spec && !vc_gnt) |-> !deq);

  p_close_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && front_type[1]) |=> !busy);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vc_req && !sw_req && !deq));

  p_port_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_req && !vc_gnt) |=> $stable(req_port));

  p_rc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !vc_req);

  p_held_nonspec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !vc_req) |-> !sw_spec);

endmodule

bind vc_seq vc_seq_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .front_type(front_type), .vc_req(vc_req),
  .vc_gnt(vc_gnt), .sw_req(sw_req), .sw_gnt(sw_gnt), .sw_spec(sw_spec),
  .credit_ok(credit_ok), .deq(deq), .busy(busy), .req_port(req_port)
);

// File: tb/vc_seq_tb.sv
`timescale 1ns/1ps
module vc_seq_tb;

  logic clk = 1'b0;
  logic rst_n, spec_en, front_valid, route_valid, vc_gnt, sw_gnt, credit_ok;
  logic [1:0] front_type;
  logic [2:0] route_port;
  logic [1:0] vc_gnt_id;
  logic vc_req, sw_req, sw_spec, deq, busy;
  logic [2:0] req_port;
  logic [1:0] out_vc;

  always #5 clk = ~clk;

  vc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .spec_en(spec_en), .front_valid(front_valid),
    .front_type(front_type), .route_valid(route_valid), .route_port(route_port),
    .vc_gnt(vc_gnt), .vc_gnt_id(vc_gnt_id), .sw_gnt(sw_gnt), .credit_ok(credit_ok),
    .vc_req(vc_req), .sw_req(sw_req), .sw_spec(sw_spec), .req_port(req_port),
    .out_vc(out_vc), .deq(deq), .busy(busy)
  );

  int checks = 0, fails = 0;
  logic [1:0] q [0:7];
  int qi = 0, qn = 0;
  logic r_vc, r_sw, r_spec, r_deq, r_busy;
  logic [2:0] r_port;
  logic [1:0] r_ovc;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic load(input int n, input logic [1:0] a, input logic [1:0] b,
                      input logic [1:0] c, input logic [1:0] d);
    q[0] = a; q[1] = b; q[2] = c; q[3] = d; qn = n; qi = 0;
  endtask

  // one cycle, starting and ending at a falling edge; grants answer requests
  task automatic step(input bit ro, input bit vo, input bit so, input bit cr);
    front_valid = (qi < qn);
    if (qi < qn) front_type = q[qi]; else front_type = 2'b01;
    route_valid = ro; route_port = ro ? 3'd3 : 3'd1; credit_ok = cr;
    vc_gnt = 1'b0; sw_gnt = 1'b0;
    #1;
    vc_gnt = vc_req & vo; sw_gnt = sw_req & so;
    #1;
    r_vc = vc_req; r_sw = sw_req; r_spec = sw_spec; r_deq = deq; r_busy = busy;
    r_port = req_port; r_ovc = out_vc;
    @(posedge clk); @(negedge clk);
    if (r_deq) qi++;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; spec_en = 1'b1; front_valid = 1'b1; front_type = 2'b00;
    route_valid = 1'b1; route_port = 3'd3; vc_gnt = 1'b1; sw_gnt = 1'b1;
    credit_ok = 1'b1; vc_gnt_id = 2'd2;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", busy, 0); chk("R1 vc_req", vc_req, 0); chk("R1 sw_req", sw_req, 0);
    chk("R1 sw_spec", sw_spec, 0); chk("R1 deq", deq, 0);
    @(negedge clk);
    rst_n = 1'b1; spec_en = 1'b0; front_valid = 1'b0; vc_gnt = 1'b0; sw_gnt = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_basic;
    spec_en = 1'b0; load(4, 2'b00, 2'b01, 2'b01, 2'b10);
    for (int t = 0; t < 8; t++) begin
      step(1, 1, 1, 1);
      chk(t == 3 ? "R2 open deq" : "R3 deq order", r_deq, (t >= 3 && t <= 6));
      if (t == 2) chk("R2 vc_req c2", r_vc, 1);
      if (t == 3) begin chk("R14 out_vc", r_ovc, 2); chk("R14 req_port", r_port, 3); end
      if (t == 7) chk("R4 idle after close", r_busy, 0);
    end
  endtask

  task automatic t_back2back;
    spec_en = 1'b0; load(3, 2'b00, 2'b10, 2'b11, 2'b00);
    for (int t = 0; t < 10; t++) begin
      step(1, 1, 1, 1);
      chk("R5 deq timing", r_deq, (t == 3 || t == 4 || t == 8));
      if (t == 5 || t == 6) chk("R5 no early vc_req", r_vc, 0);
      if (t == 5) chk("R4 idle after close", r_busy, 0);
      if (t == 9) chk("R4 idle after single", r_busy, 0);
    end
  endtask

  task automatic t_stalls;
    spec_en = 1'b0; load(2, 2'b00, 2'b10, 2'b00, 2'b00);
    step(1, 1, 1, 1);                                 // t0 idle -> RC
    for (int t = 1; t < 3; t++) begin
      step(0, 1, 1, 1); chk("R6 rc stall", r_vc | r_sw, 0);
    end
    step(1, 1, 1, 1); chk("R6 rc release", r_vc, 0); // t3 route accepted
    for (int t = 4; t < 6; t++) begin
      step(0, 0, 1, 1);
      chk("R7 vc_req held", r_vc, 1); chk("R7 no sw_req", r_sw, 0);
      chk("R14 port latched", r_port, 3);
    end
    step(0, 1, 1, 1); chk("R7 va granted", r_deq, 0); // t6
    step(0, 1, 1, 0); chk("R8 no credit", r_sw | r_deq, 0);
    step(0, 1, 0, 1); chk("R9 req no grant", r_sw, 1); chk("R9 no deq", r_deq, 0);
    step(0, 1, 1, 1); chk("R9 deq on grant", r_deq, 1);
    step(0, 1, 1, 1); chk("R3 close deq", r_deq, 1);
    step(0, 1, 1, 1); chk("R4 idle", r_busy, 0);
  endtask

  task automatic t_spec_ok;
    spec_en = 1'b1; load(3, 2'b00, 2'b01, 2'b10, 2'b00);
    for (int t = 0; t < 6; t++) begin
      step(1, 1, 1, 1);
      chk("R10 deq timing", r_deq, (t >= 2 && t <= 4));
      if (t == 2) begin chk("R10 vc_req", r_vc, 1); chk("R10 spec", r_spec, 1); end
      if (t == 3) begin chk("R12 held nonspec", r_spec, 0); chk("R12 sw_req", r_sw, 1); end
      if (t == 5) chk("R4 idle", r_busy, 0);
    end
    spec_en = 1'b0;
  endtask

  task automatic t_spec_fail;
    spec_en = 1'b1; load(2, 2'b00, 2'b10, 2'b00, 2'b00);
    step(1, 1, 1, 1); step(1, 1, 1, 1);
    step(1, 0, 1, 1); chk("R11 lone sw grant", r_deq, 0); chk("R11 spec", r_spec, 1);
    step(1, 1, 0, 1); chk("R11 retry both", r_vc & r_spec, 1); chk("R11 no deq", r_deq, 0);
    step(1, 1, 1, 1); chk("R11 nonspec after va", r_spec, 0); chk("R11 deq", r_deq, 1);
    step(1, 1, 1, 1); chk("R3 close deq", r_deq, 1);
    step(1, 1, 1, 1); chk("R4 idle", r_busy, 0);
    spec_en = 1'b0;
  endtask

  task automatic t_ignore;
    load(1, 2'b01, 2'b00, 2'b00, 2'b00);
    for (int t = 0; t < 3; t++) begin
      step(1, 1, 1, 1);
      chk("R13 no request", r_vc | r_sw | r_deq, 0); chk("R13 busy", r_busy, 0);
    end
    load(1, 2'b10, 2'b00, 2'b00, 2'b00);
    step(1, 1, 1, 1); chk("R13 close ignored", r_vc | r_sw | r_busy, 0);
    qn = 0; qi = 0;
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_basic;
    t_back2back;
    t_stalls;
    t_spec_ok;
    t_spec_fail;
    t_ignore;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule